// File: doc/BRIEF.md
# Prescaled Free-Running Timer Counter

This block is the time base of a timer subsystem. A 16-bit counter counts upward, advancing once every 2^N clock cycles, where N comes from a 3-bit prescale select. A 7-bit divider that runs freely sets the pace. When the counter rolls over from all-ones to zero, a one-cycle overflow pulse is raised. The same divider also provides a one-cycle tick every 64 cycles, which is meant to drive a pulse accumulator placed next to this block.

Software reaches the block through a small register port with four addresses. The control byte has four fields: run enable, halt-while-waiting, halt-on-debug-freeze and fast flag clearing. The count can be read in several ways: as a full word, as a high byte alone, or as a low byte alone. Reading the high byte latches the low byte that goes with it, so a later low-byte read returns the matching half. Software cannot write the count. A word write reaches it only while the test-mode input is high, and such a write leaves the divider's phase unchanged.

Top module: `prescaled_timer`

## Requirements
- R1: After reset the count reads 0x0000, the control byte reads 0x00, and tick64, ovfPulse and fastClear are all low.
- R2: While running with prescale select S, the count goes up by exactly 1 every 2^S clock cycles and never goes down.
- R3: The count wraps from 0xFFFF to 0x0000. ovfPulse is high for exactly one cycle, and that cycle is the first one in which the count reads 0x0000.
- R4: A word write to address 0 loads busWdata into the count only while testMode is 1. While testMode is 0 the write leaves the count unchanged.
- R5: The control byte at address 3 uses bit 7 for run enable, bit 6 for halt-while-waiting, bit 5 for halt-on-freeze and bit 4 for fast flag clear. Bits 3..0 and 15..8 always read 0, and writes to them have no effect.
- R6: While the run-enable bit is 0, the count holds its value and tick64 stays low.
- R7: When waitMode is 1 and the halt-while-waiting bit is 1, the count holds and tick64 stays low. When the bit is 0, counting continues through wait.
- R8: While running, tick64 is a one-cycle pulse that occurs exactly once every 64 cycles, independent of the prescale select.
- R9: When dbgFreeze is 1 and the halt-on-freeze bit is 1, the count holds and still reads back correctly. When that bit is 0, dbgFreeze has no effect.
- R10: A read at address 0 returns all 16 count bits taken from the same cycle.
- R11: A read at address 1 returns the high byte in bits 7..0 and latches the current low byte. The next read at address 2 returns the latched byte and clears the latch. A read at address 2 with no latch held returns the live low byte.
- R12: The fastClear output follows control bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| testMode | input | 1 | Enables word writes to the count |
| waitMode | input | 1 | Device is in wait mode |
| dbgFreeze | input | 1 | Debug freeze request |
| preSel | input | 3 | Prescale select; count period is 2^preSel cycles |
| busAddr | input | 2 | 0 word count, 1 high byte, 2 low byte, 3 control |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe (drives the byte-latch side effects) |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr, combinational |
| tick64 | output | 1 | Divide-by-64 pulse for a pulse accumulator |
| ovfPulse | output | 1 | One-cycle counter wrap pulse |
| fastClear | output | 1 | Fast flag clear mode for neighbouring flag logic |

## Verification
Errors in the divider or the step decode appear as a wrong count delta at the end of a window of 128 cycles. A misplaced wrap shows up as an overflow pulse that is missing, doubled, or out of line with the 0x0000 reading, within a few cycles of loading a value just below the wrap. If the run or freeze gating leaks, the count keeps moving, or ticks appear, while the block should be halted. A stale or missing byte latch is exposed on the very next low-byte read after the count has been reloaded.

// File: rtl/prescaled_timer_pkg.sv
package prescaled_timer_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ADDR_WORD = 2'd0,
    ADDR_HIGH = 2'd1,
    ADDR_LOW  = 2'd2,
    ADDR_CTRL = 2'd3
  } tmrAddr_t;

  // strobes from control to datapath
  typedef struct packed {
    logic runEn;      // divider and tick may advance
    logic cntHold;    // debug freeze holds the count
    logic loadCount;  // test-mode word write
    logic latchLow;   // high-byte read: capture low byte
    logic dropHold;   // low-byte read: release captured byte
  } tmrStrobes_t;

endpackage

// File: rtl/prescaled_timer_ctrl.sv
module prescaled_timer_ctrl
  import prescaled_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              testMode,
  input  logic              waitMode,
  input  logic              dbgFreeze,
  input  logic [1:0]        busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [3:0]        ctrlWdata,
  input  logic [CNT_W-1:0]  countVal,
  input  logic [BYTE_W-1:0] lowHold,
  input  logic              holdValid,
  output tmrStrobes_t       stb,
  output logic [CNT_W-1:0]  busRdata,
  output logic              fastClear
);

  logic enBit, waitStopBit, freezeBit, fastClrBit;
  logic ctrlWrite;

  assign ctrlWrite = busWr && (busAddr == ADDR_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enBit       <= 1'b0;
      waitStopBit <= 1'b0;
      freezeBit   <= 1'b0;
      fastClrBit  <= 1'b0;
    end else if (ctrlWrite) begin
      enBit       <= ctrlWdata[3];
      waitStopBit <= ctrlWdata[2];
      freezeBit   <= ctrlWdata[1];
      fastClrBit  <= ctrlWdata[0];
    end
  end

  always_comb begin
    stb.runEn     = enBit && !(waitStopBit && waitMode);
    stb.cntHold   = freezeBit && dbgFreeze;
    stb.loadCount = busWr && testMode && (busAddr == ADDR_WORD);
    stb.latchLow  = busRd && (busAddr == ADDR_HIGH);
    stb.dropHold  = busRd && (busAddr == ADDR_LOW);
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_WORD: busRdata = countVal;
      ADDR_HIGH: busRdata[BYTE_W-1:0] = countVal[CNT_W-1 -: BYTE_W];
      ADDR_LOW:  busRdata[BYTE_W-1:0] = holdValid ? lowHold : countVal[BYTE_W-1:0];
      default:   busRdata[BYTE_W-1:0] = {enBit, waitStopBit, freezeBit, fastClrBit, 4'b0000};
    endcase
  end

  assign fastClear = fastClrBit;

  // R12: fast clear output tracks the last written control bit 4
  a_r12_fastclear_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrlWrite) |-> fastClear == $past(ctrlWdata[0]));

endmodule

// File: rtl/prescaled_timer_dp.sv
module prescaled_timer_dp
  import prescaled_timer_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PRE_W     = 7,
  parameter int SEL_W     = 3,
  parameter int TICK_BITS = 6,
  parameter bit COHERENT  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmrStrobes_t       stb,
  input  logic [SEL_W-1:0]  preSel,
  input  logic [CNT_W-1:0]  loadVal,
  output logic [CNT_W-1:0]  countVal,
  output logic [BYTE_W-1:0] lowHold,
  output logic              holdValid,
  output logic              tick64,
  output logic              ovfPulse
);

  logic [PRE_W-1:0] presc;
  logic [PRE_W-1:0] preMask;
  logic             stepNow, incNow;

  // mask of low divider bits that must be all ones for a step
  assign preMask = ~({PRE_W{1'b1}} << preSel);
  assign stepNow = stb.runEn && ((presc & preMask) == preMask);
  assign incNow  = stepNow && !stb.cntHold;

  // free-running divider, never touched by a count load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc  <= '0;
      tick64 <= 1'b0;
    end else begin
      if (stb.runEn) presc <= presc + PRE_W'(1);
      tick64 <= stb.runEn && (presc[TICK_BITS-1:0] == {TICK_BITS{1'b1}});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      countVal <= '0;
      ovfPulse <= 1'b0;
    end else begin
      ovfPulse <= 1'b0;
      if (stb.loadCount) begin
        countVal <= loadVal;
      end else if (incNow) begin
        countVal <= countVal + CNT_W'(1);
        ovfPulse <= (countVal == {CNT_W{1'b1}});
      end
    end
  end

  generate
    if (COHERENT) begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lowHold   <= '0;
          holdValid <= 1'b0;
        end else if (stb.latchLow) begin
          lowHold   <= countVal[BYTE_W-1:0];
          holdValid <= 1'b1;
        end else if (stb.dropHold) begin
          holdValid <= 1'b0;
        end
      end

      // R11: a high-byte read captures the low byte of that same cycle
      a_r11_low_latched: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stb.latchLow) |-> holdValid && lowHold == $past(countVal[BYTE_W-1:0]));
    end else begin : g_nohold
      assign lowHold   = '0;
      assign holdValid = 1'b0;
    end
  endgenerate

  // R2: without a load the count only stays or steps by one
  a_r2_up_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stb.loadCount) |->
      (countVal == $past(countVal)) || (countVal == $past(countVal) + CNT_W'(1)));

  // R3: overflow pulse marks the wrap into zero
  a_r3_ovf_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ovfPulse |-> countVal == '0 && $past(countVal) == {CNT_W{1'b1}});

  // R4: a count load leaves the divider phase alone
  a_r4_presc_kept: assert property (@(posedge clk) disable iff (!rst_n)
    stb.loadCount |=> presc == PRE_W'($past(presc) + PRE_W'($past(stb.runEn))));

  // R6 / R7: while halted nothing advances and no tick leaves
  a_r6_halted_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stb.runEn) && !$past(stb.loadCount) |-> countVal == $past(countVal) && !tick64);

  // R9: freeze holds the count
  a_r9_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stb.cntHold) && !$past(stb.loadCount) |-> countVal == $past(countVal));

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import prescaled_timer_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PRE_W     = 7,
  parameter int TICK_BITS = 6,
  parameter bit COHERENT  = 1'b1,
  localparam int SEL_W    = $clog2(PRE_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             testMode,
  input  logic             waitMode,
  input  logic             dbgFreeze,
  input  logic [SEL_W-1:0] preSel,
  input  logic [1:0]       busAddr,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [CNT_W-1:0] busWdata,
  output logic [CNT_W-1:0] busRdata,
  output logic             tick64,
  output logic             ovfPulse,
  output logic             fastClear
);

  tmrStrobes_t       stb;
  logic [CNT_W-1:0]  countVal;
  logic [BYTE_W-1:0] lowHold;
  logic              holdValid;

  prescaled_timer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .testMode  (testMode),
    .waitMode  (waitMode),
    .dbgFreeze (dbgFreeze),
    .busAddr   (busAddr),
    .busWr     (busWr),
    .busRd     (busRd),
    .ctrlWdata (busWdata[7:4]),
    .countVal  (countVal),
    .lowHold   (lowHold),
    .holdValid (holdValid),
    .stb       (stb),
    .busRdata  (busRdata),
    .fastClear (fastClear)
  );

  prescaled_timer_dp #(
    .CNT_W     (CNT_W),
    .PRE_W     (PRE_W),
    .SEL_W     (SEL_W),
    .TICK_BITS (TICK_BITS),
    .COHERENT  (COHERENT)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .preSel    (preSel),
    .loadVal   (busWdata),
    .countVal  (countVal),
    .lowHold   (lowHold),
    .holdValid (holdValid),
    .tick64    (tick64),
    .ovfPulse  (ovfPulse)
  );

endmodule

// File: tb/prescaled_timer_test.sv
module prescaled_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        testMode = 1'b0, waitMode = 1'b0, dbgFreeze = 1'b0;
  logic [2:0]  preSel = 3'd0;
  logic [1:0]  busAddr = 2'd0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [15:0] busWdata = 16'h0;
  logic [15:0] busRdata;
  logic        tick64, ovfPulse, fastClear;

  int checks = 0, fails = 0;
  int tickSeen = 0;
  logic tickPrev = 1'b0;
  int tickWide = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  prescaled_timer uut (
    .clk(clk), .rst_n(rst_n), .testMode(testMode), .waitMode(waitMode),
    .dbgFreeze(dbgFreeze), .preSel(preSel), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata),
    .tick64(tick64), .ovfPulse(ovfPulse), .fastClear(fastClear)
  );

  always @(negedge clk) begin
    if (tick64) tickSeen++;
    if (tick64 && tickPrev) tickWide++;
    tickPrev = tick64;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(logic [1:0] a, logic [15:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busAddr = 2'd0;
  endtask

  task automatic rdReg(logic [1:0] a, output logic [15:0] v);
    busAddr = a; busRd = 1'b1;
    #1 v = busRdata;
    @(negedge clk);
    busRd = 1'b0; busAddr = 2'd0;
  endtask

  task automatic testLoad(logic [15:0] d);
    testMode = 1'b1;
    wrReg(2'd0, d);
    testMode = 1'b0;
  endtask

  // count delta over a 128-cycle window
  task automatic windowDelta(output int delta);
    logic [15:0] a, b;
    rdReg(2'd0, a);
    idle(127);
    rdReg(2'd0, b);
    delta = int'(16'(b - a));
  endtask

  task automatic tReset();
    logic [15:0] v;
    rdReg(2'd0, v); check("R1 count", v, 16'h0);
    rdReg(2'd3, v); check("R1 ctrl", v, 16'h0);
    check("R1 outputs", {tick64, ovfPulse, fastClear}, 3'b000);
  endtask

  task automatic tTestWrite();
    logic [15:0] v;
    wrReg(2'd0, 16'h1234);
    rdReg(2'd0, v); check("R4 write ignored", v, 16'h0);
    testLoad(16'h1234);
    rdReg(2'd0, v); check("R4 test write", v, 16'h1234);
    rdReg(2'd0, v); check("R10 word read", v, 16'h1234);
  endtask

  task automatic tCtrl();
    logic [15:0] v;
    wrReg(2'd3, 16'hFFFF);
    rdReg(2'd3, v); check("R5 reserved bits", v, 16'h00F0);
    check("R12 fastClear set", fastClear, 1'b1);
    wrReg(2'd3, 16'h0010);
    rdReg(2'd3, v); check("R5 field write", v, 16'h0010);
    wrReg(2'd3, 16'h0000);
    check("R12 fastClear clear", fastClear, 1'b0);
  endtask

  task automatic tRates();
    int d;
    wrReg(2'd3, 16'h0080);
    for (int s = 0; s < 8; s += 3) begin
      preSel = 3'(s);
      idle(2);
      windowDelta(d);
      check($sformatf("R2 rate sel %0d", s), d, 128 >> s);
    end
    preSel = 3'd0;
  endtask

  task automatic tWrap();
    int ovfs = 0;
    logic [15:0] atOvf = 16'hAAAA;
    logic [15:0] v;
    testLoad(16'hFFFD);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (ovfPulse) begin ovfs++; atOvf = busRdata; end
    end
    check("R3 one ovf pulse", ovfs, 1);
    check("R3 count at ovf", atOvf, 16'h0000);
    #1 v = busRdata;
    check("R3 count after wrap", v, 16'h0005);
  endtask

  task automatic tDisable();
    int d;
    wrReg(2'd3, 16'h0000);
    idle(2);
    tickSeen = 0;
    windowDelta(d);
    check("R6 count holds", d, 0);
    check("R6 no tick", tickSeen, 0);
  endtask

  task automatic tWait();
    int d;
    wrReg(2'd3, 16'h00C0);
    waitMode = 1'b1;
    idle(2);
    tickSeen = 0;
    windowDelta(d);
    check("R7 wait halts count", d, 0);
    check("R7 wait halts tick", tickSeen, 0);
    wrReg(2'd3, 16'h0080);
    idle(2);
    windowDelta(d);
    check("R7 runs in wait", d, 128);
    waitMode = 1'b0;
  endtask

  task automatic tTick();
    for (int s = 0; s < 8; s += 7) begin
      preSel = 3'(s);
      idle(3);
      tickSeen = 0; tickWide = 0;
      idle(256);
      check($sformatf("R8 ticks sel %0d", s), tickSeen, 4);
      check("R8 tick width", tickWide, 0);
    end
    preSel = 3'd0;
  endtask

  task automatic tFreeze();
    int d;
    logic [15:0] a, b;
    dbgFreeze = 1'b1;
    wrReg(2'd3, 16'h00A0);
    idle(2);
    rdReg(2'd0, a);
    idle(50);
    rdReg(2'd0, b);
    check("R9 frozen count", b, a);
    wrReg(2'd3, 16'h0080);
    idle(2);
    windowDelta(d);
    check("R9 freeze bit clear", d, 128);
    dbgFreeze = 1'b0;
    rdReg(2'd0, a);
    rdReg(2'd0, b);
    check("R10 consecutive word reads", 16'(b - a), 16'h0001);
  endtask

  task automatic tBytes();
    logic [15:0] v;
    wrReg(2'd3, 16'h0000);
    testLoad(16'h12AB);
    rdReg(2'd1, v); check("R11 high byte", v, 16'h0012);
    testLoad(16'h34CD);
    rdReg(2'd2, v); check("R11 latched low", v, 16'h00AB);
    rdReg(2'd2, v); check("R11 live low", v, 16'h00CD);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tReset();
    tTestWrite();
    tCtrl();
    tRates();
    tWrap();
    tDisable();
    tWait();
    tTick();
    tFreeze();
    tBytes();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule